// File: doc/BRIEF.md
# Hierarchical Interrupt Status Unit

This unit gathers interrupt events for a multi-queue transmit engine. Per-queue events and a handful of miscellaneous host and beacon events are latched into five secondary status words. A primary status word holds a small set of events captured directly, plus summary bits. Each summary bit reads as the OR of one group of secondary bits. Software sees all of this through a single register port.

Every status word clears on a write of ones, one bit per one written. A write of a summary bit to the primary word clears its whole secondary group. Software can also read a read-and-clear alias of the primary word. That read returns the primary value, copies every secondary word into a shadow copy and clears all live status, all in the same clock edge. An event that lands in that same cycle is still kept. A mask word gates the level interrupt output.

Top module: `irq_status_hier`

## Requirements
- R1: After reset every status, shadow and mask word reads as zero, `irq_o` is low and `rdata_o` is zero.
- R2: An event bit on a secondary input sets the matching status bit at the next clock edge, for defined positions only. Words 0, 1 and 3 hold queue fields at bits NQ-1:0 and NQ+15:16. Word 2 holds underrun at NQ-1:0, master-abort 16, system-error 17, parity-error 18, TIM 24, CAB-end 25, DTIM-sync 26, beacon-timeout 27, CAB-timeout 28, DTIM 29 and TSF-out-of-range 31. Word 4 holds triggers at NQ-1:0. All other positions ignore events.
- R3: Primary summary bits read as the OR of their groups. Bit 6 and bit 7 take the low and high fields of word 0. Bit 8 and bit 10 take the low and high fields of word 1. Bit 11 takes the word 2 underrun field, bit 19 takes word 2 bits 18:16 and bit 23 takes word 2 bits 29:24. Bit 25 and bit 26 take the low and high fields of word 3, and bit 27 takes word 4. TSF-out-of-range feeds no summary.
- R4: Direct primary bits 9, 12, 16, 17, 18, 20 and 24 are set by the primary event input at those positions. Primary event bits at any other position are ignored.
- R5: A write to a secondary word (addresses 1 to 5 for words 0 to 4) clears exactly the bits written as one. Every other bit stays set.
- R6: A write to the primary word (address 0) clears the direct bits written as one. Each summary bit written as one clears every bit of its secondary group.
- R7: When an event and a clear hit the same bit in the same cycle, the bit ends set.
- R8: A read at address 6 returns the primary value. In the same edge it copies secondary words 0 to 4 into shadows read at addresses 8 to 12, and it clears all live primary and secondary bits.
- R9: An event arriving in the same cycle as the read-and-clear stays set in the live registers after it.
- R10: The mask word is read and written at address 7. `irq_o` is high exactly while the primary value ANDed with the mask is nonzero.
- R11: A read returns its data on `rdata_o` one clock after the request. Addresses 13 to 15 read as zero.
- R12: Writes to address 6 and to the shadow addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_dir_i | input | 32 | Event pulses for direct primary bits |
| ev_s0_i | input | 32 | Event pulses for secondary word 0 |
| ev_s1_i | input | 32 | Event pulses for secondary word 1 |
| ev_s2_i | input | 32 | Event pulses for secondary word 2 |
| ev_s3_i | input | 32 | Event pulses for secondary word 3 |
| ev_s4_i | input | 32 | Event pulses for secondary word 4 |
| rd_en_i | input | 1 | Read request |
| wr_en_i | input | 1 | Write request |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt |

## Verification
Events and clears reach the status registers at the first clock edge after they are driven. The summary view and `irq_o` are combinational from those registers, so they are due in that same edge. Read data is captured at the request edge and reflects the state before that edge's updates. The bench drives each operation at the falling edge and works out the expected read value from its model before the rising edge. It advances the model at the rising edge and compares `rdata_o` and `irq_o` shortly after it. Directed sequences pin the set-beats-clear case, the group clear, the event inside a read-and-clear, and writes to read-only addresses. A seeded random stream then mixes all of these.

// File: rtl/ius_pkg.sv
package ius_pkg;
  localparam int WORD_W = 32;
  localparam int N_SEC  = 5;
  localparam int HI_OFS = 16;
  localparam int ADDR_W = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_SEC-1:0][WORD_W-1:0] sec_vec_t;

  // Register addresses
  localparam int AD_PRI  = 0;
  localparam int AD_SEC  = 1;   // words 0..4 at 1..5
  localparam int AD_RAC  = 6;
  localparam int AD_MASK = 7;
  localparam int AD_SHD  = 8;   // shadows 0..4 at 8..12

  // Primary bit positions
  localparam int PB_TXOK    = 6;
  localparam int PB_TXDESC  = 7;
  localparam int PB_TXERR   = 8;
  localparam int PB_TXNOFRM = 9;
  localparam int PB_TXEOL   = 10;
  localparam int PB_TXURN   = 11;
  localparam int PB_MIB     = 12;
  localparam int PB_SWBA    = 16;
  localparam int PB_BRSSI   = 17;
  localparam int PB_BMISS   = 18;
  localparam int PB_HIUERR  = 19;
  localparam int PB_BNR     = 20;
  localparam int PB_BCNMISC = 23;
  localparam int PB_GPIO    = 24;
  localparam int PB_CBROVR  = 25;
  localparam int PB_CBRUND  = 26;
  localparam int PB_QTRIG   = 27;

  // Secondary word 2 miscellaneous positions
  localparam int S2_MABT   = 16;
  localparam int S2_SERR   = 17;
  localparam int S2_PERR   = 18;
  localparam int S2_TIM    = 24;
  localparam int S2_CABEND = 25;
  localparam int S2_DSYNC  = 26;
  localparam int S2_BCNTO  = 27;
  localparam int S2_CABTO  = 28;
  localparam int S2_DTIM   = 29;
  localparam int S2_TSFOOR = 31;

  localparam word_t HOST_GRP = (word_t'(1) << S2_MABT) | (word_t'(1) << S2_SERR)
                             | (word_t'(1) << S2_PERR);
  localparam word_t BCN_GRP  = (word_t'(1) << S2_TIM)   | (word_t'(1) << S2_CABEND)
                             | (word_t'(1) << S2_DSYNC) | (word_t'(1) << S2_BCNTO)
                             | (word_t'(1) << S2_CABTO) | (word_t'(1) << S2_DTIM);
  localparam word_t DIRECT_MASK = (word_t'(1) << PB_TXNOFRM) | (word_t'(1) << PB_MIB)
                                | (word_t'(1) << PB_SWBA)    | (word_t'(1) << PB_BRSSI)
                                | (word_t'(1) << PB_BMISS)   | (word_t'(1) << PB_BNR)
                                | (word_t'(1) << PB_GPIO);

  // Low per-queue field: one bit per queue starting at bit 0
  function automatic word_t lo_field(int nq);
    logic [63:0] t;
    t = (64'd1 << nq) - 64'd1;
    return t[WORD_W-1:0];
  endfunction

  // High per-queue field starting at HI_OFS
  function automatic word_t hi_field(int nq);
    return lo_field(nq) << HI_OFS;
  endfunction

  // Positions of secondary word k that may hold an event
  function automatic word_t sec_valid(int k, int nq);
    word_t v;
    case (k)
      0, 1, 3: v = lo_field(nq) | hi_field(nq);
      2:       v = lo_field(nq) | HOST_GRP | BCN_GRP | (word_t'(1) << S2_TSFOOR);
      4:       v = lo_field(nq);
      default: v = '0;
    endcase
    return v;
  endfunction

  // Primary view: stored direct bits plus group summaries
  function automatic word_t summarize(word_t dir, sec_vec_t s, int nq);
    word_t p;
    p = dir & DIRECT_MASK;
    p[PB_TXOK]    = |(s[0] & lo_field(nq));
    p[PB_TXDESC]  = |(s[0] & hi_field(nq));
    p[PB_TXERR]   = |(s[1] & lo_field(nq));
    p[PB_TXEOL]   = |(s[1] & hi_field(nq));
    p[PB_TXURN]   = |(s[2] & lo_field(nq));
    p[PB_HIUERR]  = |(s[2] & HOST_GRP);
    p[PB_BCNMISC] = |(s[2] & BCN_GRP);
    p[PB_CBROVR]  = |(s[3] & lo_field(nq));
    p[PB_CBRUND]  = |(s[3] & hi_field(nq));
    p[PB_QTRIG]   = |(s[4] & lo_field(nq));
    return p;
  endfunction

  // Bits of secondary word k cleared by a write of pw to the primary word
  function automatic word_t group_clear(word_t pw, int k, int nq);
    word_t c;
    c = '0;
    case (k)
      0: begin
        if (pw[PB_TXOK])   c = c | lo_field(nq);
        if (pw[PB_TXDESC]) c = c | hi_field(nq);
      end
      1: begin
        if (pw[PB_TXERR])  c = c | lo_field(nq);
        if (pw[PB_TXEOL])  c = c | hi_field(nq);
      end
      2: begin
        if (pw[PB_TXURN])    c = c | lo_field(nq);
        if (pw[PB_HIUERR])   c = c | HOST_GRP;
        if (pw[PB_BCNMISC])  c = c | BCN_GRP;
      end
      3: begin
        if (pw[PB_CBROVR]) c = c | lo_field(nq);
        if (pw[PB_CBRUND]) c = c | hi_field(nq);
      end
      4: begin
        if (pw[PB_QTRIG])  c = c | lo_field(nq);
      end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ius_w1c_reg.sv
module ius_w1c_reg
  import ius_pkg::*;
#(
  parameter word_t VALID = '1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t set_i,
  input  word_t clr_i,
  output word_t q_o
);
  word_t q_r;
  word_t set_v;
  word_t nxt;
  logic  run_q;

  assign set_v = set_i & VALID;

  // set has priority over clear
  always_comb nxt = (q_r & ~clr_i) | set_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r   <= '0;
      run_q <= 1'b0;
    end else begin
      q_r   <= nxt;
      run_q <= 1'b1;
    end
  end

  assign q_o = q_r;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ((q_r & $past(set_v)) == $past(set_v))); // R7
  AST_KEEP_UNCLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (($past(q_r) & ~$past(clr_i) & ~q_r) == '0)); // R5
  AST_NO_STRAY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ((q_r & ~($past(q_r) | $past(set_i))) == '0)); // R2
endmodule

// File: rtl/ius_summary.sv
module ius_summary
  import ius_pkg::*;
#(
  parameter int NQ = 10
) (
  input  word_t    dir_i,
  input  sec_vec_t sec_i,
  input  word_t    mask_i,
  output word_t    pri_o,
  output logic     irq_o
);
  word_t pri_v;

  always_comb begin
    pri_v = summarize(dir_i, sec_i, NQ);
    irq_o = |(pri_v & mask_i);
  end

  assign pri_o = pri_v;
endmodule

// File: rtl/ius_regport.sv
module ius_regport
  import ius_pkg::*;
#(
  parameter int NQ = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  word_t             pri_i,
  input  sec_vec_t          sec_i,
  input  sec_vec_t          shadow_i,
  output word_t             clr_dir_o,
  output sec_vec_t          clr_sec_o,
  output logic              rac_hit_o,
  output word_t             mask_o,
  output word_t             rdata_o
);
  logic  wr_pri;
  logic  wr_mask;
  logic  rac_hit;
  logic  run_q;
  word_t mask_q;
  word_t rdata_q;
  word_t rd_val;

  assign wr_pri  = wr_en_i && (addr_i == ADDR_W'(AD_PRI));
  assign wr_mask = wr_en_i && (addr_i == ADDR_W'(AD_MASK));
  assign rac_hit = rd_en_i && (addr_i == ADDR_W'(AD_RAC));

  // clear vectors: explicit write-ones, group clears, full clear on alias read
  always_comb begin
    clr_dir_o = (wr_pri ? wdata_i : '0) | (rac_hit ? '1 : '0);
    for (int k = 0; k < N_SEC; k++) begin
      clr_sec_o[k] = (rac_hit ? '1 : '0)
                   | (wr_pri ? group_clear(wdata_i, k, NQ) : '0)
                   | ((wr_en_i && (addr_i == ADDR_W'(AD_SEC + k))) ? wdata_i : '0);
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N_SEC; k++) begin
      if (addr_i == ADDR_W'(AD_SEC + k)) rd_val = sec_i[k];
      if (addr_i == ADDR_W'(AD_SHD + k)) rd_val = shadow_i[k];
    end
    if (addr_i == ADDR_W'(AD_PRI) || addr_i == ADDR_W'(AD_RAC)) rd_val = pri_i;
    if (addr_i == ADDR_W'(AD_MASK)) rd_val = mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      rdata_q <= '0;
      run_q   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (wr_mask) mask_q <= wdata_i;
      if (rd_en_i) rdata_q <= rd_val;
    end
  end

  assign rac_hit_o = rac_hit;
  assign mask_o    = mask_q;
  assign rdata_o   = rdata_q;

  AST_RAC_RETURNS_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(rac_hit) |-> (rdata_q == $past(pri_i))); // R8
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !$past(rd_en_i) |-> (rdata_q == $past(rdata_q))); // R11
endmodule

// File: rtl/irq_status_hier.sv
module irq_status_hier
  import ius_pkg::*;
#(
  parameter int NQ = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ev_dir_i,
  input  logic [31:0] ev_s0_i,
  input  logic [31:0] ev_s1_i,
  input  logic [31:0] ev_s2_i,
  input  logic [31:0] ev_s3_i,
  input  logic [31:0] ev_s4_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  sec_vec_t ev_sec;
  sec_vec_t sec_q;
  sec_vec_t clr_sec;
  sec_vec_t shadow_q;
  word_t    dir_q;
  word_t    clr_dir;
  word_t    pri_w;
  word_t    mask_w;
  logic     rac_hit;
  logic     wr_pri;
  logic     run_q;

  assign ev_sec[0] = ev_s0_i;
  assign ev_sec[1] = ev_s1_i;
  assign ev_sec[2] = ev_s2_i;
  assign ev_sec[3] = ev_s3_i;
  assign ev_sec[4] = ev_s4_i;
  assign wr_pri    = wr_en_i && (addr_i == ADDR_W'(AD_PRI));

  ius_w1c_reg #(.VALID(DIRECT_MASK)) u_dir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev_dir_i),
    .clr_i (clr_dir),
    .q_o   (dir_q)
  );

  for (genvar k = 0; k < N_SEC; k++) begin : g_sec
    ius_w1c_reg #(.VALID(sec_valid(k, NQ))) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (ev_sec[k]),
      .clr_i (clr_sec[k]),
      .q_o   (sec_q[k])
    );
  end

  ius_summary #(.NQ(NQ)) u_sum (
    .dir_i (dir_q),
    .sec_i (sec_q),
    .mask_i(mask_w),
    .pri_o (pri_w),
    .irq_o (irq_o)
  );

  ius_regport #(.NQ(NQ)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .pri_i    (pri_w),
    .sec_i    (sec_q),
    .shadow_i (shadow_q),
    .clr_dir_o(clr_dir),
    .clr_sec_o(clr_sec),
    .rac_hit_o(rac_hit),
    .mask_o   (mask_w),
    .rdata_o  (rdata_o)
  );

  // shadow copies, loaded from pre-clear values on alias read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      run_q    <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (rac_hit) shadow_q <= sec_q;
    end
  end

  for (genvar k = 0; k < N_SEC; k++) begin : g_ast
    AST_RAC_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q && $past(rac_hit) |-> (shadow_q[k] == $past(sec_q[k]))); // R8
    AST_RAC_KEEPS_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q && $past(rac_hit) |-> (sec_q[k] == ($past(ev_sec[k]) & sec_valid(k, NQ)))); // R9
    AST_GROUP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q && $past(wr_pri) |->
        ((sec_q[k] & group_clear($past(wdata_i), k, NQ))
         == ($past(ev_sec[k]) & group_clear($past(wdata_i), k, NQ)))); // R6
    AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q && !$past(rac_hit) |-> (shadow_q[k] == $past(shadow_q[k]))); // R12
  end
endmodule

// File: tb/tb_irq_status_hier.sv
module tb_irq_status_hier;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev_dir = '0, ev0 = '0, ev1 = '0, ev2 = '0, ev3 = '0, ev4 = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_dir, m_mask;
  logic [31:0] m_sec [5];
  logic [31:0] m_sh  [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_hier #(.NQ(NQ)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_dir_i(ev_dir),
    .ev_s0_i(ev0), .ev_s1_i(ev1), .ev_s2_i(ev2), .ev_s3_i(ev3), .ev_s4_i(ev4),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] b_valid(int k);
    logic [31:0] v = '0;
    for (int q = 0; q < NQ; q++) begin
      v[q] = 1'b1;
      if (k == 0 || k == 1 || k == 3) v[q+16] = 1'b1;
    end
    if (k == 2) begin
      for (int b = 16; b <= 18; b++) v[b] = 1'b1;
      for (int b = 24; b <= 29; b++) v[b] = 1'b1;
      v[31] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [31:0] b_direct();
    return 32'h0000_0000 | (1 << 9) | (1 << 12) | (1 << 16) | (1 << 17)
         | (1 << 18) | (1 << 20) | (1 << 24);
  endfunction

  function automatic logic [31:0] b_pri();
    logic [31:0] p = m_dir & b_direct();
    for (int q = 0; q < NQ; q++) begin
      if (m_sec[0][q])    p[6]  = 1'b1;
      if (m_sec[0][q+16]) p[7]  = 1'b1;
      if (m_sec[1][q])    p[8]  = 1'b1;
      if (m_sec[1][q+16]) p[10] = 1'b1;
      if (m_sec[2][q])    p[11] = 1'b1;
      if (m_sec[3][q])    p[25] = 1'b1;
      if (m_sec[3][q+16]) p[26] = 1'b1;
      if (m_sec[4][q])    p[27] = 1'b1;
    end
    if (m_sec[2][18:16] != 0) p[19] = 1'b1;
    if (m_sec[2][29:24] != 0) p[23] = 1'b1;
    return p;
  endfunction

  function automatic logic [31:0] b_grp(logic [31:0] wd, int k);
    logic [31:0] c = '0;
    for (int q = 0; q < NQ; q++) begin
      case (k)
        0: begin if (wd[6])  c[q] = 1; if (wd[7])  c[q+16] = 1; end
        1: begin if (wd[8])  c[q] = 1; if (wd[10]) c[q+16] = 1; end
        2: begin if (wd[11]) c[q] = 1; end
        3: begin if (wd[25]) c[q] = 1; if (wd[26]) c[q+16] = 1; end
        default: begin if (wd[27]) c[q] = 1; end
      endcase
    end
    if (k == 2 && wd[19]) c[18:16] = 3'b111;
    if (k == 2 && wd[23]) c[29:24] = 6'h3f;
    return c;
  endfunction

  function automatic logic [31:0] b_read(logic [3:0] ad);
    if (ad == 0 || ad == 6) return b_pri();
    if (ad >= 1 && ad <= 5) return m_sec[ad-1];
    if (ad == 7) return m_mask;
    if (ad >= 8 && ad <= 12) return m_sh[ad-8];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] ed, e0, e1, e2, e3, e4,
                     input logic rd, wr, input logic [3:0] ad,
                     input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd;
    logic [31:0] clr_d;
    logic [31:0] clr [5];
    logic [31:0] evs [5];
    logic rac;
    @(negedge clk);
    ev_dir = ed; ev0 = e0; ev1 = e1; ev2 = e2; ev3 = e3; ev4 = e4;
    rd_en = rd; wr_en = wr; addr = ad; wdata = wd;
    evs[0] = e0; evs[1] = e1; evs[2] = e2; evs[3] = e3; evs[4] = e4;
    exp_rd = b_read(ad);
    rac = rd && ad == 6;
    clr_d = ((wr && ad == 0) ? wd : 32'h0) | (rac ? 32'hffff_ffff : 32'h0);
    for (int k = 0; k < 5; k++)
      clr[k] = ((wr && ad == 4'(k+1)) ? wd : 32'h0) | (rac ? 32'hffff_ffff : 32'h0)
             | ((wr && ad == 0) ? b_grp(wd, k) : 32'h0);
    @(posedge clk);
    #1;
    if (rac) for (int k = 0; k < 5; k++) m_sh[k] = m_sec[k];
    for (int k = 0; k < 5; k++) m_sec[k] = (m_sec[k] & ~clr[k]) | (evs[k] & b_valid(k));
    m_dir = (m_dir & ~clr_d) | (ed & b_direct());
    if (wr && ad == 7) m_mask = wd;
    if (rd) chk(tag, rdata, exp_rd);
    chk("R10 irq", {31'h0, irq}, {31'h0, |(b_pri() & m_mask)});
    ev_dir = '0; ev0 = '0; ev1 = '0; ev2 = '0; ev3 = '0; ev4 = '0;
    rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd_at(input logic [3:0] ad, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, ad, 0, tag);
  endtask

  task automatic wr_at(input logic [3:0] ad, input logic [31:0] wd);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, ad, wd, "write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (R11): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_dir = 0; m_mask = 0;
    for (int k = 0; k < 5; k++) begin m_sec[k] = 0; m_sh[k] = 0; end
    void'($urandom(32'd7391));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 16; a++) rd_at(4'(a), "R1 R11 reset read");

    // R2: defined queue bits only
    cyc(0, 32'h0000_F008 | (1 << 19), 0, 0, 0, 0, 0, 0, 0, 0, "R2 set");
    rd_at(1, "R2 sec0");
    chk("R2 sec0 literal", rdata, 32'h0008_0008);
    rd_at(0, "R3 pri");
    chk("R3 summary literal", rdata, 32'h0000_00C0);
    // R4: direct bit 12, summary position 6 on direct input ignored; TSF feeds nothing
    cyc((1 << 6) | (1 << 12), 0, 0, 32'h8000_0000, 0, 0, 0, 0, 0, 0, "R4 set");
    rd_at(0, "R4 pri");
    chk("R4 direct literal", rdata, 32'h0000_10C0);
    cyc(0, 0, 0, 1 << 27, 0, 0, 0, 0, 0, 0, "R3 set");
    rd_at(0, "R3 pri beacon");
    chk("R3 beacon literal", rdata, 32'h0080_10C0);
    // R5
    wr_at(1, 32'h0000_0008);
    rd_at(1, "R5 sec0");
    chk("R5 partial clear literal", rdata, 32'h0008_0000);
    // R6
    cyc(0, 0, (1 << 2) | (1 << 5), 0, 0, 0, 0, 0, 0, 0, "R6 set");
    wr_at(0, (1 << 8) | (1 << 12));
    rd_at(2, "R6 sec1");
    chk("R6 group clear literal", rdata, 32'h0);
    rd_at(0, "R6 pri");
    chk("R6 pri literal", rdata, 32'h0080_0080);
    // R7
    cyc(0, 0, 0, 0, 0, 32'h2, 0, 1, 5, 32'h2, "R7 collide");
    rd_at(5, "R7 sec4");
    chk("R7 set wins literal", rdata, 32'h2);
    // R8 / R9
    cyc(0, 0, 0, 0, 32'h1, 0, 0, 0, 0, 0, "R8 set");
    cyc(0, 0, 0, 0, 32'h0001_0000, 0, 1, 0, 6, 0, "R8 alias");
    chk("R8 alias literal", rdata, 32'h0A80_0080);
    rd_at(4, "R9 sec3");
    chk("R9 new event kept", rdata, 32'h0001_0000);
    rd_at(11, "R8 shadow3");
    chk("R8 shadow3 literal", rdata, 32'h1);
    rd_at(10, "R8 shadow2");
    chk("R8 shadow2 literal", rdata, 32'h8800_0000);
    // R10
    wr_at(7, 1 << 26);
    chk("R10 irq high", {31'h0, irq}, 32'h1);
    rd_at(7, "R10 mask");
    wr_at(4, 32'h0001_0000);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    // R12
    wr_at(9, 32'hffff_ffff);
    wr_at(6, 32'hffff_ffff);
    rd_at(9, "R12 shadow1");
    rd_at(11, "R12 shadow3");
    chk("R12 shadow3 literal", rdata, 32'h1);
    rd_at(0, "R12 pri");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r0 = $urandom & $urandom & $urandom;
      logic [31:0] r1 = $urandom & $urandom & $urandom;
      logic [31:0] r2 = $urandom & $urandom & $urandom;
      logic [31:0] r3 = $urandom & $urandom & $urandom;
      logic [31:0] r4 = $urandom & $urandom & $urandom;
      logic [31:0] rdir = $urandom & $urandom;
      logic [3:0]  ra = 4'($urandom_range(0, 15));
      logic        rr = ($urandom_range(0, 1) == 1);
      logic        rw = ($urandom_range(0, 2) == 0);
      logic [31:0] rwd = $urandom;
      string t;
      if (ra == 0) t = "R3 rand pri";
      else if (ra <= 5) t = "R2 R5 rand sec";
      else if (ra == 6) t = "R8 rand alias";
      else if (ra == 7) t = "R10 rand mask";
      else if (ra <= 12) t = "R12 rand shadow";
      else t = "R11 rand unmapped";
      cyc(rdir, r0, r1, r2, r3, r4, rr, rw, ra, rwd, t);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule